// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block tracks exclusive reservations for a small multiprocessor so that load-exclusive and store-exclusive pairs can build atomic read-modify-write sequences. Request port `i` belongs to processor `i`. The processor id is the port index, so no separate id field is carried. Each port presents an operation, a shared-memory flag, a physical address, an access size and a 2-bit alignment-check setting. The block answers with a write enable, a pass/fail status bit and an alignment fault. Address translation, the memory itself, register writeback and bus bursts live outside the block.

Each processor has a local monitor, built as a two-state machine with the states OPEN and EXCL. A load-exclusive takes it from OPEN to EXCL. A store-exclusive or a clear-exclusive takes it from EXCL to OPEN. EXCL stays in EXCL on a further load. All other inputs hold the current state.

Each processor also has one global entry, holding a valid bit, an address and a size. Shared loads record the entry. A successful shared store invalidates every entry, of any processor, whose byte range overlaps the stored bytes.

Requests that arrive in the same cycle are resolved in ascending port order. A lower port's effects are visible to a higher port in that cycle.

Top module: `excl_monitor`

## Requirements
- R1: Reset puts every local monitor in OPEN and invalidates every global entry. A store-exclusive issued after reset therefore fails.
- R2: A load-exclusive (op 2'b01) moves the issuing processor's local monitor to EXCL and returns write 0 and status 0. A following store-exclusive (op 2'b10) to a non-shared address writes and returns status 0.
- R3: A store-exclusive whose processor's local monitor is OPEN does not write and returns status 1. Any write enable comes with status 0.
- R4: A shared load-exclusive records its address and size in the processor's own global entry. A shared store with local EXCL writes only if that entry is valid and holds the same address and the same size. Otherwise the store does not write and returns status 1.
- R5: Every store-exclusive, whether it passes or fails, returns the local monitor to OPEN. So does a clear-exclusive (op 2'b11), which never writes and never faults.
- R6: A successful shared store invalidates every valid global entry whose byte range overlaps the stored range. This applies to entries of every processor. The size codes and their byte counts are: 2'b00 = 1 byte, 2'b01 = 2 bytes, 2'b10 or 2'b11 = 8 bytes, covering the base address and the following 7 bytes.
- R7: The alignment rules are as follows:
  - Byte accesses never fault.
  - Halfword accesses need address bit 0 clear.
  - Doubleword accesses need address bits 2:0 clear.
  - A misaligned load-exclusive or store-exclusive faults only when the alignment setting is non-zero. A faulting access returns status 1.
- R8: A faulting access does not write and leaves all local and global monitor state unchanged.
- R9: Same-cycle requests are served in ascending port order. When two processors store to the same reserved address in one cycle, the lower port succeeds and the higher port fails.
- R10: Results are registered and appear exactly one cycle after the request. An idle op (2'b00) returns all-zero results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_op | input | 2*NUM_CPU | Per-port operation: 00 idle, 01 load, 10 store, 11 clear |
| req_shared | input | NUM_CPU | Per-port shared-memory flag |
| req_addr | input | ADDR_W*NUM_CPU | Per-port physical address |
| req_size | input | 2*NUM_CPU | Per-port size: 00 byte, 01 halfword, 1x doubleword |
| req_align_cfg | input | 2*NUM_CPU | Per-port alignment-check setting; 00 disables faults |
| wr_en_o | output | NUM_CPU | Store may write memory |
| status_o | output | NUM_CPU | 0 = pass, 1 = fail or fault |
| fault_o | output | NUM_CPU | Alignment fault |

## Verification
Every result (write enable, status and fault) is due on the clock edge that follows the edge capturing the request. Monitor state changes land on that same edge, so a request issued on the next cycle already sees them. The bench drives requests on falling edges and tags each expected result with the cycle in which it is due. The monitor compares a result only on the falling edge in that cycle, which is one cycle after it was driven. Same-cycle ordering is exercised by driving both ports together.

// File: rtl/excl_pkg.sv
package excl_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_LOAD  = 2'b01,
        OP_STORE = 2'b10,
        OP_CLEAR = 2'b11
    } op_e;

    typedef enum logic {
        LM_OPEN = 1'b0,
        LM_EXCL = 1'b1
    } lmon_e;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;

    // Byte count covered by a size code.
    function automatic logic [3:0] size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_bytes = 4'd1;
            SZ_HALF: size_bytes = 4'd2;
            default: size_bytes = 4'd8;
        endcase
    endfunction
endpackage

// File: rtl/excl_align_chk.sv
module excl_align_chk
    import excl_pkg::*;
(
    input  logic [1:0] op_i,
    input  logic [1:0] size_i,
    input  logic [2:0] addr_lo_i,
    input  logic [1:0] cfg_i,
    output logic       fault_o
);
    logic misaligned;
    logic checked_op;

    always_comb begin
        unique case (size_i)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = addr_lo_i[0];
            default: misaligned = (addr_lo_i != 3'b000);
        endcase
        checked_op = (op_e'(op_i) == OP_LOAD) || (op_e'(op_i) == OP_STORE);
        fault_o    = checked_op && misaligned && (cfg_i != 2'b00);
    end
endmodule

// File: rtl/excl_local_fsm.sv
module excl_local_fsm
    import excl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  set_i,
    input  logic  clr_i,
    output lmon_e state_o
);
    lmon_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LM_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LM_OPEN: if (set_i) state_d = LM_EXCL;
            LM_EXCL: if (clr_i) state_d = LM_OPEN;
            default: state_d = LM_OPEN;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import excl_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int ADDR_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2*NUM_CPU-1:0]      req_op,
    input  logic [NUM_CPU-1:0]        req_shared,
    input  logic [ADDR_W*NUM_CPU-1:0] req_addr,
    input  logic [2*NUM_CPU-1:0]      req_size,
    input  logic [2*NUM_CPU-1:0]      req_align_cfg,
    output logic [NUM_CPU-1:0]        wr_en_o,
    output logic [NUM_CPU-1:0]        status_o,
    output logic [NUM_CPU-1:0]        fault_o
);
    localparam int EXT_W = ADDR_W + 4;

    lmon_e              lstate [NUM_CPU];
    logic [NUM_CPU-1:0] flt, set_l, clr_l, wr_d, st_d;

    logic              g_v  [NUM_CPU];
    logic [ADDR_W-1:0] g_a  [NUM_CPU];
    logic [1:0]        g_s  [NUM_CPU];
    logic              nv   [NUM_CPU];
    logic [ADDR_W-1:0] na   [NUM_CPU];
    logic [1:0]        ns   [NUM_CPU];

    // Half-open byte ranges [a, a+n) and [b, b+m) intersect.
    function automatic logic overlap(input logic [ADDR_W-1:0] a, input logic [1:0] sa,
                                     input logic [ADDR_W-1:0] b, input logic [1:0] sb);
        logic [EXT_W-1:0] ax, bx;
        ax = EXT_W'(a);
        bx = EXT_W'(b);
        overlap = (ax < bx + EXT_W'(size_bytes(sb))) && (bx < ax + EXT_W'(size_bytes(sa)));
    endfunction

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
        excl_align_chk u_align (
            .op_i      (req_op[2*g +: 2]),
            .size_i    (req_size[2*g +: 2]),
            .addr_lo_i (req_addr[g*ADDR_W +: 3]),
            .cfg_i     (req_align_cfg[2*g +: 2]),
            .fault_o   (flt[g])
        );
        excl_local_fsm u_local (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (set_l[g]),
            .clr_i   (clr_l[g]),
            .state_o (lstate[g])
        );
    end

    // Requests resolve in ascending port order on a running copy of the global entries.
    always_comb begin
        op_e               op;
        logic [ADDR_W-1:0] ad;
        logic [1:0]        sz;
        nv = g_v;
        na = g_a;
        ns = g_s;
        wr_d  = '0;
        st_d  = '0;
        set_l = '0;
        clr_l = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            op = op_e'(req_op[2*i +: 2]);
            ad = req_addr[i*ADDR_W +: ADDR_W];
            sz = req_size[2*i +: 2];
            if (flt[i]) begin
                st_d[i] = 1'b1;
            end else begin
                unique case (op)
                    OP_LOAD: begin
                        set_l[i] = 1'b1;
                        if (req_shared[i]) begin
                            nv[i] = 1'b1;
                            na[i] = ad;
                            ns[i] = sz;
                        end
                    end
                    OP_STORE: begin
                        clr_l[i] = 1'b1;
                        if (lstate[i] != LM_EXCL) begin
                            st_d[i] = 1'b1;
                        end else if (!req_shared[i]) begin
                            wr_d[i] = 1'b1;
                        end else if (nv[i] && na[i] == ad && size_bytes(ns[i]) == size_bytes(sz)) begin
                            wr_d[i] = 1'b1;
                            for (int j = 0; j < NUM_CPU; j++) begin
                                if (nv[j] && overlap(na[j], ns[j], ad, sz)) nv[j] = 1'b0;
                            end
                        end else begin
                            st_d[i] = 1'b1;
                        end
                    end
                    OP_CLEAR: clr_l[i] = 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CPU; i++) begin
                g_v[i] <= 1'b0;
                g_a[i] <= '0;
                g_s[i] <= '0;
            end
            wr_en_o  <= '0;
            status_o <= '0;
            fault_o  <= '0;
        end else begin
            for (int i = 0; i < NUM_CPU; i++) begin
                g_v[i] <= nv[i];
                g_a[i] <= na[i];
                g_s[i] <= ns[i];
            end
            wr_en_o  <= wr_d;
            status_o <= st_d;
            fault_o  <= flt;
        end
    end
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
    parameter int NUM_CPU = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2*NUM_CPU-1:0] req_op,
    input logic [2*NUM_CPU-1:0] req_size,
    input logic [NUM_CPU-1:0]   wr_en_o,
    input logic [NUM_CPU-1:0]   status_o,
    input logic [NUM_CPU-1:0]   fault_o
);
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_port
        // R8: a faulting access never enables a write
        a_r8_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
            fault_o[i] |-> !wr_en_o[i]);
        // R3: a write always reports status 0
        a_r3_write_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en_o[i] |-> !status_o[i]);
        // R2: only a store-exclusive can produce a write
        a_r2_write_from_store: assert property (@(posedge clk) disable iff (!rst_n)
            (req_op[2*i +: 2] != 2'b10) |=> !wr_en_o[i]);
        // R7: byte accesses never fault
        a_r7_byte_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
            (req_size[2*i +: 2] == 2'b00) |=> !fault_o[i]);
        // R5: a clear-exclusive neither writes nor faults
        a_r5_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (req_op[2*i +: 2] == 2'b11) |=> (!wr_en_o[i] && !fault_o[i]));
        // R10: idle yields all-zero results one cycle later
        a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (req_op[2*i +: 2] == 2'b00) |=> (!wr_en_o[i] && !status_o[i] && !fault_o[i]));
    end
endmodule

bind excl_monitor excl_monitor_chk #(.NUM_CPU(NUM_CPU)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_op   (req_op),
    .req_size (req_size),
    .wr_en_o  (wr_en_o),
    .status_o (status_o),
    .fault_o  (fault_o)
);

// File: tb/excl_monitor_bench.sv
module excl_monitor_bench;
    localparam int N  = 2;
    localparam int AW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2*N-1:0]  req_op = '0;
    logic [N-1:0]    req_shared = '0;
    logic [AW*N-1:0] req_addr = '0;
    logic [2*N-1:0]  req_size = '0;
    logic [2*N-1:0]  req_align_cfg = '0;
    logic [N-1:0]    wr_en_o, status_o, fault_o;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    typedef struct {
        int    port;
        bit    wr;
        bit    st;
        bit    fl;
        int    due;
        string tag;
    } exp_t;
    exp_t sb[$];

    excl_monitor #(.NUM_CPU(N), .ADDR_W(AW)) u_excl_monitor (
        .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_shared(req_shared),
        .req_addr(req_addr), .req_size(req_size), .req_align_cfg(req_align_cfg),
        .wr_en_o(wr_en_o), .status_o(status_o), .fault_o(fault_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares results in the cycle they are due.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            tests++;
            if (wr_en_o[e.port] !== e.wr || status_o[e.port] !== e.st || fault_o[e.port] !== e.fl) begin
                fails++;
                $display("FAIL %s port%0d: got wr=%b st=%b flt=%b, expected wr=%b st=%b flt=%b",
                         e.tag, e.port, wr_en_o[e.port], status_o[e.port], fault_o[e.port],
                         e.wr, e.st, e.fl);
            end
        end
    end

    // Driver: one cycle of requests on both ports plus expected results.
    task automatic go(input logic [1:0] o0, input bit s0, input logic [31:0] a0,
                      input logic [1:0] z0, input logic [1:0] c0, input bit [2:0] e0,
                      input logic [1:0] o1, input bit s1, input logic [31:0] a1,
                      input logic [1:0] z1, input logic [1:0] c1, input bit [2:0] e1,
                      input string tag);
        exp_t x;
        req_op        = {o1, o0};
        req_shared    = {s1, s0};
        req_addr      = {a1, a0};
        req_size      = {z1, z0};
        req_align_cfg = {c1, c0};
        x.due = cyc + 1; x.tag = tag;
        x.port = 0; {x.wr, x.st, x.fl} = e0; sb.push_back(x);
        x.port = 1; {x.wr, x.st, x.fl} = e1; sb.push_back(x);
        @(negedge clk);
        req_op = '0;
    endtask

    // Shorthands: op codes, results as {wr,st,flt}
    localparam logic [1:0] ID = 2'b00, LD = 2'b01, ST = 2'b10, CL = 2'b11;
    localparam bit [2:0] OK0 = 3'b000, WOK = 3'b100, BAD = 3'b010, FLT = 3'b011;

    initial begin
        repeat (3) @(negedge clk);
        tests++;
        if (wr_en_o !== '0 || status_o !== '0 || fault_o !== '0) begin
            fails++;
            $display("FAIL R1 reset outputs: got %b%b%b expected 000", wr_en_o, status_o, fault_o);
        end
        rst_n = 1'b1;
        @(negedge clk);
        go(ID,0,0,0,0,OK0, ID,0,0,0,0,OK0, "R10 idle");
        go(ST,1,32'h100,0,1,BAD, ST,0,32'h100,0,1,BAD, "R1 R3 store after reset");
        go(LD,0,32'h200,0,1,OK0, ID,0,0,0,0,OK0, "R2 load");
        go(ST,0,32'h200,0,1,WOK, ID,0,0,0,0,OK0, "R2 nonshared store");
        go(ST,0,32'h200,0,1,BAD, ID,0,0,0,0,OK0, "R5 store clears local");
        go(LD,0,32'h200,0,1,OK0, ID,0,0,0,0,OK0, "R5 load");
        go(CL,0,32'h207,1,3,OK0, ID,0,0,0,0,OK0, "R5 clear no fault");
        go(ST,0,32'h200,0,1,BAD, ID,0,0,0,0,OK0, "R5 store after clear");
        go(LD,1,32'h300,1,1,OK0, LD,1,32'h400,0,1,OK0, "R4 shared loads");
        go(ST,1,32'h300,0,1,BAD, ST,1,32'h401,0,1,BAD, "R4 size and address mismatch");
        go(LD,1,32'h300,1,1,OK0, ID,0,0,0,0,OK0, "R4 reload");
        go(ST,1,32'h300,1,1,WOK, ID,0,0,0,0,OK0, "R4 matching shared store");
        go(LD,1,32'h504,0,1,OK0, LD,1,32'h500,2,1,OK0, "R6 loads");
        go(ST,1,32'h504,0,1,WOK, ID,0,0,0,0,OK0, "R6 byte store inside doubleword");
        go(ID,0,0,0,0,OK0, ST,1,32'h500,2,1,BAD, "R6 other entry cleared");
        go(LD,1,32'h600,1,1,OK0, LD,1,32'h600,1,1,OK0, "R9 loads");
        go(ST,1,32'h600,1,1,WOK, ST,1,32'h600,1,1,BAD, "R9 port order");
        go(LD,0,32'h701,1,1,FLT, LD,0,32'h704,2,2,FLT, "R7 misaligned faults");
        go(LD,0,32'h703,0,3,OK0, LD,0,32'h701,1,0,OK0, "R7 byte and cfg 00");
        go(CL,0,0,0,0,OK0, CL,0,0,0,0,OK0, "R5 clears");
        go(LD,0,32'h701,1,1,FLT, LD,0,32'h800,0,1,OK0, "R8 faulting load");
        go(ST,0,32'h700,0,1,BAD, ST,0,32'h801,1,1,FLT, "R8 no local set, faulting store");
        go(ID,0,0,0,0,OK0, ST,0,32'h800,0,1,WOK, "R8 local kept after fault");
        go(LD,0,32'h900,0,1,OK0, ID,0,0,0,0,OK0, "R1 load before reset");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        go(ST,0,32'h900,0,1,BAD, ID,0,0,0,0,OK0, "R1 reset drops reservation");
        @(negedge clk);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #100000;
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule